// File: doc/BRIEF.md
# Table-Coded Clock Divider

This block derives a slower clock from an input clock. The division ratio is not programmed directly. A small code selects one entry of a fixed lookup table, and the step from code to ratio is irregular. One table, for example, gives ratios 8, 9, 10 and 15 for codes 0 to 3. A build-time parameter chooses which of five tables an instance carries. One of the tables is sparse: only two of its codes mean anything.

Software places a code on the code input and pulses the apply strobe for one input-clock cycle. A legal code is captured at once but takes effect only when the running output period ends, so the output never has a cut-short phase. An undefined code is refused. The divider keeps its current ratio and raises a flag that stays up until a legal code is applied. Each output period starts with its low phase. Odd ratios put the spare input cycle in the low phase.

Top module: `coded_clk_div`

## Requirements
- R1: With TABLE_SEL=0, codes 0, 1, 2 and 3 give division ratios 8, 9, 10 and 15. Codes 4 to 15 are undefined.
- R2: With TABLE_SEL=1, codes 0 to 3 give ratios 8, 16, 24 and 32. All other codes are undefined.
- R3: With TABLE_SEL=2, codes 0 to 7 give ratios 9, 10, 11, 12, 13, 14, 16 and 18. Codes 8 to 15 are undefined.
- R4: With TABLE_SEL=3, codes 0 to 4 give ratios 2, 3, 4, 8 and 16. Codes 5 to 15 are undefined.
- R5: With TABLE_SEL=4 (sparse table), code 7 gives ratio 8 and code 15 gives ratio 16. Every other code is undefined.
- R6: When an undefined code is applied, `codeIllegal` is 1 from the next clock edge and the ratio in use does not change. Applying a legal code returns `codeIllegal` to 0 at the next edge.
- R7: `divCode` is sampled only on an edge where `applyStb` is 1. With `applyStb` at 0, neither the ratio nor `codeIllegal` changes.
- R8: A ratio captured by an apply is first used for the output period that starts after the capture edge. The running period finishes at its old ratio, and every output phase lasts at least the smallest high phase the table allows.
- R9: A period of ratio N is ceil(N/2) input cycles low, followed by floor(N/2) input cycles high.
- R10: While `rstN` is 0, `clkOut` and `codeIllegal` are 0. After reset the divider runs at the ratio of code 0, or of code 7 for the sparse table, and the first period starts with its low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous reset, active low |
| divCode | input | CODE_W | Code that selects the table entry |
| applyStb | input | 1 | One-cycle strobe that samples `divCode` |
| clkOut | output | 1 | Divided clock |
| codeIllegal | output | 1 | Set when the last applied code was undefined |

## Verification
Five instances run side by side, one per table. Each is walked through its codes in a non-monotonic order, so a table that has been shifted or reordered shows up as wrong low and high lengths, not just a wrong period. Undefined codes are placed between legal ones. This tells a refused code, which keeps the old ratio, apart from one the divider wrongly decodes, and shows that the flag clears again. A code change with no strobe, a reset in the middle of a run, and the extreme ratios 2 and 32 cover the edges of the counter and the reset path.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int RATIO_W = 6;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic   legal;
    ratio_t ratio;
  } ratioEntry_t;

  // control -> datapath: ratio waiting for the next period and its low length
  typedef struct packed {
    ratio_t ratio;
    ratio_t lowLen;
  } divCmd_t;

  function automatic ratioEntry_t lookupRatio(input int tableSel, input int unsigned code);
    int r;
    ratioEntry_t e;
    r = 0;
    case (tableSel)
      0: case (code)
           0: r = 8;
           1: r = 9;
           2: r = 10;
           3: r = 15;
           default: r = 0;
         endcase
      1: r = (code < 4) ? 8 * (int'(code) + 1) : 0;
      2: case (code)
           0, 1, 2, 3, 4, 5: r = 9 + int'(code);
           6: r = 16;
           7: r = 18;
           default: r = 0;
         endcase
      3: case (code)
           0: r = 2;
           1: r = 3;
           2: r = 4;
           3: r = 8;
           4: r = 16;
           default: r = 0;
         endcase
      4: case (code)
           7:  r = 8;
           15: r = 16;
           default: r = 0;
         endcase
      default: r = 0;
    endcase
    e.legal = (r != 0);
    e.ratio = ratio_t'(r);
    return e;
  endfunction

  function automatic int unsigned resetCode(input int tableSel);
    return (tableSel == 4) ? 7 : 0;
  endfunction

  function automatic ratio_t halfLow(input ratio_t n);
    return ratio_t'((int'(n) + 1) / 2);
  endfunction

  // smallest high phase over every legal code of a table
  function automatic int minHalf(input int tableSel, input int codeCount);
    int best;
    ratioEntry_t e;
    best = 1 << RATIO_W;
    for (int c = 0; c < codeCount; c++) begin
      e = lookupRatio(tableSel, c);
      if (e.legal && (int'(e.ratio) / 2) < best) best = int'(e.ratio) / 2;
    end
    return best;
  endfunction

endpackage

// File: rtl/cdiv_ctrl.sv
module cdiv_ctrl
  import cdiv_pkg::*;
#(
  parameter int TABLE_SEL = 0,
  parameter int CODE_W    = 4,
  parameter ratio_t RESET_RATIO = 8
) (
  input  logic              clkIn,
  input  logic              rstN,
  input  logic [CODE_W-1:0] divCode,
  input  logic              applyStb,
  output divCmd_t           cmd,
  output logic              codeIllegal
);

  ratioEntry_t decoded;
  ratio_t      pendRatio;
  ratio_t      pendLow;

  assign decoded = lookupRatio(TABLE_SEL, 32'(divCode));

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      pendRatio   <= RESET_RATIO;
      pendLow     <= halfLow(RESET_RATIO);
      codeIllegal <= 1'b0;
    end else if (applyStb) begin
      codeIllegal <= !decoded.legal;
      if (decoded.legal) begin
        pendRatio <= decoded.ratio;
        pendLow   <= halfLow(decoded.ratio);
      end
    end
  end

  assign cmd.ratio  = pendRatio;
  assign cmd.lowLen = pendLow;

endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
  import cdiv_pkg::*;
#(
  parameter ratio_t RESET_RATIO = 8
) (
  input  logic    clkIn,
  input  logic    rstN,
  input  divCmd_t cmd,
  output logic    clkOut
);

  ratio_t cnt;
  ratio_t cntNext;
  ratio_t actRatio;
  ratio_t actLow;
  logic   wrap;

  assign cntNext = cnt + ratio_t'(1);
  assign wrap    = (cntNext == actRatio);

  // ratio is swapped only on the wrap edge, where the output goes low anyway
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      actRatio <= RESET_RATIO;
      actLow   <= halfLow(RESET_RATIO);
      clkOut   <= 1'b0;
    end else if (wrap) begin
      cnt      <= '0;
      actRatio <= cmd.ratio;
      actLow   <= cmd.lowLen;
      clkOut   <= 1'b0;
    end else begin
      cnt      <= cntNext;
      clkOut   <= (cntNext >= actLow);
    end
  end

endmodule

// File: rtl/coded_clk_div.sv
module coded_clk_div
  import cdiv_pkg::*;
#(
  parameter int TABLE_SEL = 0,
  parameter int CODE_W    = 4
) (
  input  logic              clkIn,
  input  logic              rstN,
  input  logic [CODE_W-1:0] divCode,
  input  logic              applyStb,
  output logic              clkOut,
  output logic              codeIllegal
);

  localparam ratio_t RESET_RATIO = lookupRatio(TABLE_SEL, resetCode(TABLE_SEL)).ratio;

  divCmd_t cmdBus;

  cdiv_ctrl #(
    .TABLE_SEL  (TABLE_SEL),
    .CODE_W     (CODE_W),
    .RESET_RATIO(RESET_RATIO)
  ) uCtrl (
    .clkIn      (clkIn),
    .rstN       (rstN),
    .divCode    (divCode),
    .applyStb   (applyStb),
    .cmd        (cmdBus),
    .codeIllegal(codeIllegal)
  );

  cdiv_core #(
    .RESET_RATIO(RESET_RATIO)
  ) uCore (
    .clkIn (clkIn),
    .rstN  (rstN),
    .cmd   (cmdBus),
    .clkOut(clkOut)
  );

endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker
  import cdiv_pkg::*;
#(
  parameter int TABLE_SEL = 0,
  parameter int CODE_W    = 4
) (
  input logic              clkIn,
  input logic              rstN,
  input logic [CODE_W-1:0] divCode,
  input logic              applyStb,
  input logic              clkOut,
  input logic              codeIllegal,
  input divCmd_t           cmdBus
);

  localparam int MIN_HALF = minHalf(TABLE_SEL, 1 << CODE_W);

  ratioEntry_t chkEntry;
  logic        prevOut;
  logic [7:0]  runCnt;
  logic [7:0]  lowLen;
  logic        lowSeen;
  logic        riseNow;
  logic        fallNow;

  assign chkEntry = lookupRatio(TABLE_SEL, 32'(divCode));
  assign riseNow  = clkOut && !prevOut;
  assign fallNow  = !clkOut && prevOut;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      prevOut <= 1'b0;
      runCnt  <= '0;
      lowLen  <= '0;
      lowSeen <= 1'b0;
    end else begin
      prevOut <= clkOut;
      runCnt  <= (clkOut != prevOut) ? 8'd1 : runCnt + 8'd1;
      if (riseNow) begin
        lowLen  <= runCnt;
        lowSeen <= 1'b1;
      end
    end
  end

  // R10: output and flag held low in reset
  always_ff @(posedge clkIn) begin
    if (!rstN) begin
      a_r10_reset_low: assert (!clkOut && !codeIllegal)
        else $error("R10 output or flag high during reset");
    end
  end

  a_r6_illegal_sets: assert property (@(posedge clkIn) disable iff (!rstN)
    (applyStb && !chkEntry.legal) |=> (codeIllegal && $stable(cmdBus.ratio)))
    else $error("R6 undefined code not refused");

  a_r6_legal_clears: assert property (@(posedge clkIn) disable iff (!rstN)
    (applyStb && chkEntry.legal) |=> !codeIllegal)
    else $error("R6 flag not cleared by legal code");

  a_r7_hold_when_idle: assert property (@(posedge clkIn) disable iff (!rstN)
    !applyStb |=> ($stable(codeIllegal) && $stable(cmdBus.ratio)))
    else $error("R7 state moved without strobe");

  a_r9_duty: assert property (@(posedge clkIn) disable iff (!rstN)
    (fallNow && lowSeen) |-> ((runCnt == lowLen) || (runCnt + 8'd1 == lowLen)))
    else $error("R9 high phase does not match low phase");

  a_r8_no_runt: assert property (@(posedge clkIn) disable iff (!rstN)
    (riseNow || fallNow) |-> (runCnt >= 8'(MIN_HALF)))
    else $error("R8 runt phase");

endmodule

bind coded_clk_div cdiv_checker #(
  .TABLE_SEL(TABLE_SEL),
  .CODE_W   (CODE_W)
) uChk (
  .clkIn      (clkIn),
  .rstN       (rstN),
  .divCode    (divCode),
  .applyStb   (applyStb),
  .clkOut     (clkOut),
  .codeIllegal(codeIllegal),
  .cmdBus     (cmdBus)
);

// File: tb/tb_coded_clk_div.sv
module tb_coded_clk_div;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_INST   = 5;
  localparam int CODE_W     = 4;
  localparam int NUM_VEC    = 22;

  // {table[2:0], code[3:0], legal, low[4:0], high[4:0]}
  localparam logic [17:0] VECS [NUM_VEC] = '{
    {3'd0, 4'd1,  1'b1, 5'd5,  5'd4},
    {3'd0, 4'd3,  1'b1, 5'd8,  5'd7},
    {3'd0, 4'd2,  1'b1, 5'd5,  5'd5},
    {3'd0, 4'd4,  1'b0, 5'd5,  5'd5},
    {3'd0, 4'd0,  1'b1, 5'd4,  5'd4},
    {3'd1, 4'd1,  1'b1, 5'd8,  5'd8},
    {3'd1, 4'd3,  1'b1, 5'd16, 5'd16},
    {3'd1, 4'd2,  1'b1, 5'd12, 5'd12},
    {3'd1, 4'd5,  1'b0, 5'd12, 5'd12},
    {3'd2, 4'd0,  1'b1, 5'd5,  5'd4},
    {3'd2, 4'd6,  1'b1, 5'd8,  5'd8},
    {3'd2, 4'd7,  1'b1, 5'd9,  5'd9},
    {3'd2, 4'd8,  1'b0, 5'd9,  5'd9},
    {3'd2, 4'd5,  1'b1, 5'd7,  5'd7},
    {3'd3, 4'd1,  1'b1, 5'd2,  5'd1},
    {3'd3, 4'd0,  1'b1, 5'd1,  5'd1},
    {3'd3, 4'd4,  1'b1, 5'd8,  5'd8},
    {3'd3, 4'd5,  1'b0, 5'd8,  5'd8},
    {3'd3, 4'd3,  1'b1, 5'd4,  5'd4},
    {3'd4, 4'd15, 1'b1, 5'd8,  5'd8},
    {3'd4, 4'd3,  1'b0, 5'd8,  5'd8},
    {3'd4, 4'd7,  1'b1, 5'd4,  5'd4}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [CODE_W-1:0] codeArr  [NUM_INST];
  logic              applyArr [NUM_INST];
  logic              outArr   [NUM_INST];
  logic              illArr   [NUM_INST];

  int checks = 0;
  int failures = 0;
  int curLo [NUM_INST] = '{4, 4, 5, 1, 4};
  int curHi [NUM_INST] = '{4, 4, 4, 1, 4};

  for (genvar g = 0; g < NUM_INST; g++) begin : gInst
    coded_clk_div #(.TABLE_SEL(g), .CODE_W(CODE_W)) dut (
      .clkIn      (clk),
      .rstN       (rstN),
      .divCode    (codeArr[g]),
      .applyStb   (applyArr[g]),
      .clkOut     (outArr[g]),
      .codeIllegal(illArr[g])
    );
  end

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic string tableReq(input int t);
    case (t)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic applyCode(input int idx, input int code);
    @(negedge clk);
    codeArr[idx]  = CODE_W'(code);
    applyArr[idx] = 1'b1;
    @(negedge clk);
    applyArr[idx] = 1'b0;
  endtask

  // one full period, starting at a falling edge of the output
  task automatic measure(input int idx, output int lo, output int hi);
    logic prev;
    logic cur;
    prev = outArr[idx];
    forever begin
      @(negedge clk);
      cur = outArr[idx];
      if (prev && !cur) break;
      prev = cur;
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (outArr[idx]) break;
      lo++;
    end
    hi = 1;
    forever begin
      @(negedge clk);
      if (!outArr[idx]) break;
      hi++;
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finishRun();
  end

  initial begin
    int lo;
    int hi;
    for (int i = 0; i < NUM_INST; i++) begin
      codeArr[i]  = '0;
      applyArr[i] = 1'b0;
    end

    // R10: reset state
    repeat (3) @(negedge clk);
    for (int i = 0; i < NUM_INST; i++) begin
      check("R10", "clkOut in reset", int'(outArr[i]), 0);
      check("R10", "codeIllegal in reset", int'(illArr[i]), 0);
    end
    rstN = 1'b1;

    // R10 + R9: ratio after reset, low phase first
    for (int i = 0; i < NUM_INST; i++) begin
      measure(i, lo, hi);
      check("R10", "reset-ratio low", lo, curLo[i]);
      check("R10", "reset-ratio high", hi, curHi[i]);
    end

    // vector walk over all tables
    for (int v = 0; v < NUM_VEC; v++) begin
      int t;
      int code;
      int legal;
      int expLo;
      int expHi;
      string req;
      t     = int'(VECS[v][17:15]);
      code  = int'(VECS[v][14:11]);
      legal = int'(VECS[v][10]);
      expLo = int'(VECS[v][9:5]);
      expHi = int'(VECS[v][4:0]);
      req   = (legal != 0) ? tableReq(t) : "R6";
      applyCode(t, code);
      check("R6", $sformatf("flag t%0d code%0d", t, code), int'(illArr[t]), 1 - legal);
      measure(t, lo, hi);
      check({"R8 ", req}, "first boundary period low", lo, expLo);
      check({"R8 ", req}, "first boundary period high", hi, expHi);
      measure(t, lo, hi);
      check({req, ",R9"}, $sformatf("low t%0d code%0d", t, code), lo, expLo);
      check({req, ",R9"}, $sformatf("high t%0d code%0d", t, code), hi, expHi);
      curLo[t] = expLo;
      curHi[t] = expHi;
    end

    // R7: code change without strobe is ignored
    @(negedge clk);
    codeArr[0] = 4'd3;
    measure(0, lo, hi);
    measure(0, lo, hi);
    check("R7", "low after unstrobed code", lo, curLo[0]);
    check("R7", "high after unstrobed code", hi, curHi[0]);
    check("R7", "flag after unstrobed code", int'(illArr[0]), 0);

    // R6: flag stays set while table 1 sits on a refused code
    check("R6", "flag persists", int'(illArr[1]), 1);

    // R10: reset in mid-run returns to the reset ratio
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R10", "clkOut in second reset", int'(outArr[1]), 0);
    check("R10", "flag cleared by reset", int'(illArr[1]), 0);
    @(negedge clk);
    rstN = 1'b1;
    measure(1, lo, hi);
    check("R10", "t1 low after second reset", lo, 4);
    check("R10", "t1 high after second reset", hi, 4);
    measure(4, lo, hi);
    check("R10", "t4 low after second reset", lo, 4);
    check("R10", "t4 high after second reset", hi, 4);

    finishRun();
  end

endmodule